// File: doc/BRIEF.md
# Staged Multi-Mode Word Shifter

This block moves an 8-bit word by any distance from 0 to 7 positions in one combinational pass. It offers three operations: logical shift, arithmetic shift and rotation, each in either direction. The pass is built from three cascaded stages. The first stage moves the word by 4 positions, the second by 2 and the third by 1. Each stage acts only when its bit of the shift amount is set.

At every bit position, a stage picks one of three values: the bit unchanged, its neighbour from the left path or its neighbour from the right path. At the end of the word, a second small selector fills each vacated position. Rotation fills it with the bit that leaves the other end. An arithmetic right shift fills it with a copy of the original most significant bit. All other cases fill it with zero.

A parameter can add an output register on the result. This register has an asynchronous active-low reset. It suits placement at the end of an ALU datapath where the result is wanted a cycle later.

Top module: `stage_shifter`

## Requirements
- R1: When the shift amount is 0, the output equals the input word in every mode and in both directions.
- R2: Logical left shift by k (mode 2'b00, direction bit 0) gives (data << k) truncated to 8 bits, with zeros entering at bit 0.
- R3: Logical right shift by k (mode 2'b00, direction bit 1) gives data >> k, with zeros entering at bit 7.
- R4: Arithmetic right shift by k (mode 2'b01, direction bit 1) fills the k upper positions with copies of input bit 7.
- R5: Arithmetic left shift (mode 2'b01, direction bit 0) fills with zeros, so it gives the same result as the logical left shift.
- R6: Rotate left by k (mode 2'b10, direction bit 0) moves bit i to position (i+k) mod 8, so no bit is lost.
- R7: Rotate right by k (mode 2'b10, direction bit 1) gives the same word as rotate left by (8-k) mod 8.
- R8: Mode code 2'b11 behaves exactly as logical mode 2'b00 for both directions.
- R9: With the output register enabled (the default), the output shows the result of the inputs sampled at a rising clock edge one edge later. The output is 0 while rst_ni is low, and it drops to 0 without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Asynchronous active-low reset of the output register |
| data_i | input | 8 | Word to be shifted |
| amt_i | input | 3 | Shift distance, 0 to 7 |
| dir_i | input | 1 | 0 = left, 1 = right |
| mode_i | input | 2 | 00 logical, 01 arithmetic, 10 rotate, 11 logical |
| data_o | output | 8 | Shifted word (registered when REG_OUT = 1) |

## Verification
Two functions can meet in the same cycle: the capture of a fresh result by the output register, and the asynchronous reset that clears it. The bench provokes this by loading a nonzero word in rotate mode and then lowering rst_ni between clock edges. It then expects data_o to read 0 at once and to stay 0 across the next edge, while the inputs still present a nonzero result. The bench judges every other vector through a scoreboard. It covers every combination of word, amount, direction and mode, and compares each output against a model written from the requirements.

// File: rtl/stage_shifter_pkg.sv
package stage_shifter_pkg;
  typedef enum logic [1:0] {
    OP_LOGIC = 2'b00,
    OP_ARITH = 2'b01,
    OP_ROT   = 2'b10,
    OP_ALT   = 2'b11
  } shift_op_e;

  localparam logic DIR_LEFT  = 1'b0;
  localparam logic DIR_RIGHT = 1'b1;
endpackage

// File: rtl/shift_op_decode.sv
module shift_op_decode
  import stage_shifter_pkg::*;
(
  input  logic [1:0] mode_i,
  output logic       rot_o,
  output logic       arith_o
);
  shift_op_e op;

  always_comb begin
    op      = shift_op_e'(mode_i);
    rot_o   = 1'b0;
    arith_o = 1'b0;
    unique case (op)
      OP_ROT:   rot_o   = 1'b1;
      OP_ARITH: arith_o = 1'b1;
      default:  ; // logical and the spare code
    endcase
  end

  always_comb begin
    if (!$isunknown(mode_i)) begin
      assert_spare_is_logic_R8: assert (!(mode_i == 2'b11) || (!rot_o && !arith_o))
        else $error("spare mode not decoded as logical");
      assert_fill_exclusive_R4: assert ($onehot0({rot_o, arith_o}))
        else $error("rotate and arithmetic both selected");
    end
  end
endmodule

// File: rtl/shift_stage.sv
module shift_stage #(
  parameter int W    = 8,
  parameter int DIST = 4
) (
  input  logic [W-1:0] word_i,
  input  logic         en_i,
  input  logic         dir_i,
  input  logic         rot_i,
  input  logic         arith_i,
  input  logic         sign_i,
  output logic [W-1:0] word_o
);
  localparam int KEEP = W - DIST;

  logic [W-1:0] left_w;
  logic [W-1:0] right_w;

  for (genvar i = 0; i < W; i++) begin : g_bit
    // left path: vacated low bits take wrap or zero
    if (i >= DIST) begin : g_lsrc
      assign left_w[i] = word_i[i-DIST];
    end else begin : g_lfill
      assign left_w[i] = rot_i ? word_i[i+KEEP] : 1'b0;
    end
    // right path: vacated high bits take wrap, sign or zero
    if (i < KEEP) begin : g_rsrc
      assign right_w[i] = word_i[i+DIST];
    end else begin : g_rfill
      assign right_w[i] = rot_i ? word_i[i-KEEP] : (arith_i & sign_i);
    end

    always_comb begin
      unique case ({en_i, dir_i})
        2'b10:   word_o[i] = left_w[i];
        2'b11:   word_o[i] = right_w[i];
        default: word_o[i] = word_i[i];
      endcase
    end
  end

  always_comb begin
    if (!$isunknown({word_i, en_i, dir_i, rot_i, arith_i, sign_i})) begin
      assert_stage_pass_R1: assert (en_i || word_o == word_i)
        else $error("idle stage altered the word");
      assert_rotate_keeps_bits_R6: assert (!rot_i || $countones(word_o) == $countones(word_i))
        else $error("rotation lost or added bits");
      assert_logic_never_adds_R2: assert (rot_i || arith_i || $countones(word_o) <= $countones(word_i))
        else $error("logical shift introduced ones");
      assert_sign_fill_R4: assert (!(en_i && dir_i && arith_i && !rot_i) || word_o[W-1] == sign_i)
        else $error("arithmetic right did not fill with sign");
      assert_left_zero_fill_R5: assert (!(en_i && !dir_i && !rot_i) || word_o[DIST-1:0] == '0)
        else $error("left shift filled with nonzero");
    end
  end
endmodule

// File: rtl/shift_out_reg.sv
module shift_out_reg #(
  parameter int W       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o <= '0;
      else         q_o <= d_i;
    end
  end else begin : g_comb
    assign q_o = d_i;
  end
endmodule

// File: rtl/stage_shifter.sv
module stage_shifter
  import stage_shifter_pkg::*;
#(
  parameter int W       = 8,
  parameter bit REG_OUT = 1'b1,
  localparam int SW     = $clog2(W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [W-1:0]  data_i,
  input  logic [SW-1:0] amt_i,
  input  logic          dir_i,
  input  logic [1:0]    mode_i,
  output logic [W-1:0]  data_o
);
  logic          rot;
  logic          arith;
  logic [W-1:0]  chain [SW+1];

  shift_op_decode u_dec (
    .mode_i  (mode_i),
    .rot_o   (rot),
    .arith_o (arith)
  );

  assign chain[0] = data_i;

  // largest distance first: amount bit SW-1 drives stage 0
  for (genvar s = 0; s < SW; s++) begin : g_stage
    localparam int DIST = 1 << (SW - 1 - s);
    shift_stage #(.W(W), .DIST(DIST)) u_stage (
      .word_i  (chain[s]),
      .en_i    (amt_i[SW-1-s]),
      .dir_i   (dir_i),
      .rot_i   (rot),
      .arith_i (arith),
      .sign_i  (data_i[W-1]),
      .word_o  (chain[s+1])
    );
  end

  shift_out_reg #(.W(W), .REG_OUT(REG_OUT)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (chain[SW]),
    .q_o    (data_o)
  );

  if (REG_OUT) begin : g_chk
    logic past_ok;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) past_ok <= 1'b0;
      else         past_ok <= 1'b1;
    end

    assert_zero_amount_pass_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (past_ok && $past(amt_i) == '0) |-> data_o == $past(data_i))
      else $error("zero amount did not pass word");

    assert_rotate_weight_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (past_ok && $past(mode_i) == 2'b10) |-> $countones(data_o) == $countones($past(data_i)))
      else $error("rotate result weight mismatch");

    assert_reset_clears_R9: assert property (@(posedge clk_i)
      !rst_ni |-> data_o == '0)
      else $error("output not cleared in reset");
  end
endmodule

// File: tb/stage_shifter_test.sv
module stage_shifter_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] data_i = '0;
  logic [2:0] amt_i = '0;
  logic       dir_i = 1'b0;
  logic [1:0] mode_i = '0;
  logic [7:0] data_o;

  int errors = 0;
  int checks = 0;
  bit run_mon = 1'b0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
    logic [7:0] din;
    int         k;
    logic       dir;
    logic [1:0] mode;
  } item_t;

  item_t sb[$];

  stage_shifter uut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .data_i (data_i),
    .amt_i  (amt_i),
    .dir_i  (dir_i),
    .mode_i (mode_i),
    .data_o (data_o)
  );

  always #2 clk_i = ~clk_i;

  function automatic logic [7:0] model(logic [7:0] d, int k, logic dir, logic [1:0] mode);
    logic signed [7:0] sd;
    sd = d;
    if (k == 0) return d;
    if (mode == 2'b10) begin
      if (dir) return (d >> k) | (d << (8 - k));
      else     return (d << k) | (d >> (8 - k));
    end
    if (mode == 2'b01 && dir) return sd >>> k;
    if (dir) return d >> k;
    return d << k;
  endfunction

  function automatic string tag_of(int k, logic dir, logic [1:0] mode);
    if (k == 0)        return "R1";
    if (mode == 2'b11) return "R8";
    if (mode == 2'b10) return dir ? "R7" : "R6";
    if (mode == 2'b01) return dir ? "R4" : "R5";
    return dir ? "R3" : "R2";
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic drive(logic [7:0] d, int k, logic dir, logic [1:0] mode);
    item_t it;
    @(negedge clk_i);
    data_i = d; amt_i = 3'(k); dir_i = dir; mode_i = mode;
    it.exp = model(d, k, dir, mode);
    it.tag = tag_of(k, dir, mode);
    it.din = d; it.k = k; it.dir = dir; it.mode = mode;
    sb.push_back(it);
  endtask

  // monitor: result of an edge is sampled 1 ns after it
  initial begin
    forever begin
      @(posedge clk_i);
      #1;
      if (run_mon && sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        check(it.tag, data_o, it.exp);
      end
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(150000 * 4);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=done");
    summary();
  end

  initial begin
    data_i = 8'hA5;
    mode_i = 2'b10;
    repeat (3) @(posedge clk_i);
    #1;
    check("R9", data_o, 8'h00); // held in reset
    @(negedge clk_i);
    rst_ni = 1'b1;
    run_mon = 1'b1;

    // directed corner cases
    drive(8'h80, 7, 1'b1, 2'b01); // R4 full sign fill -> FF
    drive(8'h80, 7, 1'b1, 2'b00); // R3 -> 01
    drive(8'h81, 1, 1'b1, 2'b10); // R7 -> C0
    drive(8'h81, 7, 1'b0, 2'b10); // R7 pair: left 7 == right 1
    drive(8'hFF, 4, 1'b0, 2'b01); // R5 -> F0
    drive(8'hC3, 5, 1'b1, 2'b11); // R8 -> 06

    // exhaustive sweep
    for (int m = 0; m < 4; m++)
      for (int dr = 0; dr < 2; dr++)
        for (int k = 0; k < 8; k++)
          for (int d = 0; d < 256; d++)
            drive(8'(d), k, 1'(dr), 2'(m));

    repeat (3) @(posedge clk_i);
    #1;
    check("R9", 8'(sb.size()), 8'h00);

    // reset meets capture: nonzero result pending, reset between edges
    run_mon = 1'b0;
    @(negedge clk_i);
    data_i = 8'h3C; amt_i = 3'd2; dir_i = 1'b0; mode_i = 2'b10;
    @(posedge clk_i);
    #1;
    check("R9", data_o, 8'hF0);
    #0.5;
    rst_ni = 1'b0;
    #0.5;
    check("R9", data_o, 8'h00); // cleared without an edge
    @(posedge clk_i);
    #1;
    check("R9", data_o, 8'h00); // stays clear over the edge
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i);
    #1;
    check("R9", data_o, 8'hF0); // capture resumes one edge later

    summary();
  end
endmodule